// File: doc/BRIEF.md
# Serial Byte Receiver with Echo Offset

This block receives bytes from an asynchronous serial line in 8N1 format (one start bit, eight data bits sent least significant first, one stop bit, idle level high). It runs from a system clock much faster than the bit rate. The defaults are a 100 MHz clock and 9600 baud, which gives 10417 clocks per bit. The incoming pin passes through a three-flop synchronizer. A falling edge on the idle line starts a frame, and the receiver confirms the start bit half a bit period later. From then on it decides each bit one bit period apart, so every decision falls near the bit centre. Each decision is a majority vote of three samples spaced a few clocks apart, the last taken at the centre itself.

A complete byte appears on `rx_byte` with a one-cycle `rx_valid` strobe. A frame whose stop bit reads low gives a one-cycle `rx_frame_err` and no byte. The receiver re-arms at the centre of the stop bit, so a sender whose clock runs slightly fast is still followed.

An echo stage adds a fixed offset (default 2) to each received byte and presents it on a request/acknowledge transmit interface. It holds one byte. A byte that arrives while the previous one is still unacknowledged is dropped and reported by a one-cycle overrun pulse.

Top module: `serial_echo_rx`

## Requirements
- R1: The pin is sampled through a 3-flop synchronizer that resets to 1, and only the last flop feeds the receive logic. With a falling edge on the pin that is stable from clock edge 1, `rx_valid` is high in the cycle after clock edge 4 + CLK_PER_BIT/2 + 9*CLK_PER_BIT.
- R2: A falling edge while idle starts a frame only if the vote at the half-bit point reads 0. A low pulse shorter than half a bit produces no byte and no error, and the receiver takes the next frame normally.
- R3: The eight data bits are decided one bit period apart after the start decision and are assembled least significant bit first. At the stop-bit decision, `rx_byte` carries the byte and `rx_valid` is high for exactly one cycle.
- R4: Each decision is the majority of three samples of the synchronized line, taken VOTE_GAP*2 clocks before the centre, VOTE_GAP clocks before it, and at the centre. An inverted pin level lasting one clock at a bit centre does not change the received byte.
- R5: The receiver returns to idle at the stop-bit decision. A next start bit that begins CLK_PER_BIT/2 + 3 clocks after the stop bit began is received correctly.
- R6: When the stop-bit vote is 0, `rx_frame_err` is high for one cycle and `rx_valid` stays low. The receiver then waits for a high line before it accepts a new start edge.
- R7: A received byte b is offered as `tx_data` = (b + OFFSET) mod 256 with `tx_req` high from the next cycle. `tx_req` and `tx_data` hold until a cycle with `tx_ack` high, after which `tx_req` falls. A byte that arrives in the same cycle as the acknowledge is accepted.
- R8: A byte that arrives while `tx_req` is high and `tx_ack` is low is dropped. `tx_overrun` is high for one cycle, and `tx_data` keeps the earlier value.
- R9: While `rst_n` is low, at a clock edge, `rx_valid`, `rx_frame_err`, `tx_req` and `tx_overrun` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_pin | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` is new |
| rx_frame_err | output | 1 | One-cycle strobe: stop bit read as 0 |
| tx_data | output | DATA_W | Pending echo byte (received byte + OFFSET) |
| tx_req | output | 1 | Echo byte pending, held until acknowledged |
| tx_ack | input | 1 | Transmitter takes the pending byte |
| tx_overrun | output | 1 | One-cycle strobe: a byte was dropped because the echo slot was full |

## Verification
A bit counter or phase counter that is off shows at the ports within one frame. Either `rx_valid` lands outside its expected cycle, or the byte comes out shifted by one position, or a false framing error appears at the stop decision. A wrong vote or a wrong sample point shows as a wrong byte only when the pin carries a short glitch at the centre, so the bench injects one-clock glitches at data-bit centres. A stuck echo slot shows one cycle after the next strobe, because the per-cycle model compares `tx_req`, `tx_data` and `tx_overrun` on every clock.

// File: rtl/serial_rx_pkg.sv
// Shared types and helpers for the serial echo receiver.
// Assumes: no state beyond the declarations here.
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    // Two-of-three majority
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Multi-flop synchronizer for the asynchronous serial input.
// Assumes: the line idles high, so all flops reset to 1.
module rx_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // shift the pin into the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
// Frame receiver: start-edge detection, half-bit confirmation, centre
// sampling with a three-sample vote, LSB-first assembly and a stop check.
// Assumes: line is already synchronized; 2*VOTE_GAP < CLK_PER_BIT/2.
module rx_framer
    import serial_rx_pkg::*;
#(
    parameter int CLK_PER_BIT = 10417,
    parameter int VOTE_GAP    = 4,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    output logic [DATA_W-1:0] byte_o,
    output logic              valid_o,
    output logic              ferr_o
);
    localparam int HALF  = CLK_PER_BIT / 2;
    localparam int CNT_W = $clog2(CLK_PER_BIT + 1);
    localparam int IDX_W = $clog2(DATA_W + 1);

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   target;
    logic [IDX_W-1:0]   bit_idx;
    logic [DATA_W-1:0]  shreg;
    logic               prev_line;
    logic               smp_a, smp_b;
    logic               at_a, at_b, at_dec, vote;

    // decision point: half a bit for the start bit, a full bit afterwards
    always_comb begin
        target = (state == RX_START) ? CNT_W'(HALF - 1) : CNT_W'(CLK_PER_BIT - 1);
        at_a   = (cnt == target - CNT_W'(2 * VOTE_GAP));
        at_b   = (cnt == target - CNT_W'(VOTE_GAP));
        at_dec = (cnt == target);
        vote   = vote3(smp_a, smp_b, line);
    end

    // frame sequencing, sampling and output strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            byte_o    <= '0;
            prev_line <= 1'b1;
            smp_a     <= 1'b1;
            smp_b     <= 1'b1;
            valid_o   <= 1'b0;
            ferr_o    <= 1'b0;
        end else begin
            prev_line <= line;
            valid_o   <= 1'b0;
            ferr_o    <= 1'b0;
            if (at_a) smp_a <= line;
            if (at_b) smp_b <= line;
            case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (prev_line && !line) state <= RX_START;
                end
                RX_START: begin
                    if (at_dec) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= vote ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (at_dec) begin
                        cnt   <= '0;
                        shreg <= {vote, shreg[DATA_W-1:1]};
                        if (bit_idx == IDX_W'(DATA_W - 1)) state <= RX_STOP;
                        else bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_dec) begin
                        cnt <= '0;
                        if (vote) begin
                            byte_o  <= shreg;
                            valid_o <= 1'b1;
                            state   <= RX_IDLE;
                        end else begin
                            ferr_o <= 1'b1;
                            state  <= RX_WAIT_HIGH;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_WAIT_HIGH: begin
                    cnt <= '0;
                    if (line) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/echo_stage.sv
// One-byte echo slot: adds a constant to each received byte and offers it
// with a request held until acknowledged; a byte arriving into a full slot
// is dropped and flagged.
// Assumes: in_valid is a single-cycle strobe.
module echo_stage #(
    parameter int DATA_W = 8,
    parameter int OFFSET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              ack,
    output logic [DATA_W-1:0] out_byte,
    output logic              req,
    output logic              overrun
);
    // slot fill, drain and overrun detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= '0;
            req      <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            overrun <= 1'b0;
            if (req && ack) req <= 1'b0;
            if (in_valid) begin
                if (req && !ack) begin
                    overrun <= 1'b1;
                end else begin
                    req      <= 1'b1;
                    out_byte <= in_byte + DATA_W'(OFFSET);
                end
            end
        end
    end
endmodule

// File: rtl/serial_echo_rx.sv
// Top: synchronizer, frame receiver and echo slot in series.
// Assumes: rx_pin idles high; tx_ack is synchronous to clk.
module serial_echo_rx #(
    parameter int CLK_PER_BIT = 10417,
    parameter int VOTE_GAP    = 4,
    parameter int SYNC_STAGES = 3,
    parameter int DATA_W      = 8,
    parameter int OFFSET      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_pin,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_frame_err,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_req,
    input  logic              tx_ack,
    output logic              tx_overrun
);
    logic line_s;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_pin),
        .sync_out (line_s)
    );

    rx_framer #(
        .CLK_PER_BIT (CLK_PER_BIT),
        .VOTE_GAP    (VOTE_GAP),
        .DATA_W      (DATA_W)
    ) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (line_s),
        .byte_o  (rx_byte),
        .valid_o (rx_valid),
        .ferr_o  (rx_frame_err)
    );

    echo_stage #(.DATA_W(DATA_W), .OFFSET(OFFSET)) u_echo (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_byte  (rx_byte),
        .in_valid (rx_valid),
        .ack      (tx_ack),
        .out_byte (tx_data),
        .req      (tx_req),
        .overrun  (tx_overrun)
    );
endmodule

// File: rtl/serial_echo_rx_chk.sv
// Port-level properties of the serial echo receiver, bound to the top.
module serial_echo_rx_chk #(
    parameter int DATA_W = 8,
    parameter int OFFSET = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_valid,
    input logic              rx_frame_err,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_req,
    input logic              tx_ack,
    input logic              tx_overrun
);
    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_err_excl_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> !rx_valid);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ack && !rx_valid) |=> (tx_req && $stable(tx_data)));

    assert_echo_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (!tx_req || tx_ack)) |=>
            (tx_req && tx_data == ($past(rx_byte) + DATA_W'(OFFSET))));

    assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && tx_req && !tx_ack) |=> (tx_overrun && tx_req && $stable(tx_data)));
endmodule

bind serial_echo_rx serial_echo_rx_chk #(.DATA_W(DATA_W), .OFFSET(OFFSET)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_byte      (rx_byte),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .tx_data      (tx_data),
    .tx_req       (tx_req),
    .tx_ack       (tx_ack),
    .tx_overrun   (tx_overrun)
);

// File: tb/serial_echo_rx_bench.sv
module serial_echo_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BIT        = 32;
    localparam int HALF       = BIT / 2;
    localparam int GAP        = 4;
    localparam int OFS        = 2;
    localparam int LATENCY    = 4 + HALF + 9 * BIT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b1;
    logic [7:0] rx_byte, tx_data;
    logic       rx_valid, rx_frame_err, tx_req, tx_overrun;
    logic       tx_ack = 1'b0;

    serial_echo_rx #(
        .CLK_PER_BIT (BIT),
        .VOTE_GAP    (GAP),
        .SYNC_STAGES (3),
        .DATA_W      (8),
        .OFFSET      (OFS)
    ) u_serial_echo_rx (
        .clk (clk), .rst_n (rst_n), .rx_pin (rx_pin),
        .rx_byte (rx_byte), .rx_valid (rx_valid), .rx_frame_err (rx_frame_err),
        .tx_data (tx_data), .tx_req (tx_req), .tx_ack (tx_ack), .tx_overrun (tx_overrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int start_cyc = 0;
    bit lat_chk = 1'b0;
    bit run = 1'b0;
    bit done = 1'b0;
    bit ack_en = 1'b1;
    int ovr_seen = 0;
    int exp_q[$];
    // reference model of the echo slot
    bit       m_pend = 1'b0;
    bit       m_ovr = 1'b0;
    bit [7:0] m_data = 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    always @(posedge clk) cyc++;

    // per-clock comparison against expected events and the echo model
    always @(negedge clk) begin
        if (run) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte", rx_byte, 0);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(e >= 0, "R6 byte where framing error expected", rx_byte, e);
                    if (e >= 0) chk(rx_byte == e[7:0], "R3 received byte", rx_byte, e);
                end
                if (lat_chk) begin
                    chk((cyc - start_cyc) >= LATENCY - 1 && (cyc - start_cyc) <= LATENCY + 1,
                        "R1 strobe latency", cyc - start_cyc, LATENCY);
                    lat_chk = 1'b0;
                end
            end
            if (rx_frame_err) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected framing error", 1, 0);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(e < 0, "R6 framing error flag", 1, e);
                end
            end
            chk(tx_req == m_pend, "R7 tx_req", tx_req, m_pend);
            if (m_pend) chk(tx_data == m_data, "R7 tx_data", tx_data, m_data);
            chk(tx_overrun == m_ovr, "R8 tx_overrun", tx_overrun, m_ovr);
            if (tx_overrun) ovr_seen++;
            tx_ack = ack_en;
            begin
                bit np, no;
                bit [7:0] nd;
                np = m_pend; nd = m_data; no = 1'b0;
                if (m_pend && tx_ack) np = 1'b0;
                if (rx_valid) begin
                    if (m_pend && !tx_ack) no = 1'b1;
                    else begin np = 1'b1; nd = rx_byte + 8'(OFS); end
                end
                m_pend = np; m_data = nd; m_ovr = no;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); rx_pin = 1'b1; end
    endtask

    // glitch_c: clock index within the frame to invert (-1 none)
    task automatic send_frame(input bit [7:0] b, input int stop_len, input int glitch_c,
                              input bit bad_stop);
        bit bits[10];
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[i + 1] = b[i];
        bits[9] = ~bad_stop;
        exp_q.push_back(bad_stop ? -1 : int'(b));
        for (int c = 0; c < 9 * BIT + stop_len; c++) begin
            @(negedge clk);
            if (c == 0) start_cyc = cyc;
            rx_pin = bits[(c / BIT) > 9 ? 9 : c / BIT] ^ (c == glitch_c);
        end
    endtask

    initial begin : main
        repeat (5) @(negedge clk);
        chk(!rx_valid && !rx_frame_err && !tx_req && !tx_overrun, "R9 reset outputs",
            {rx_valid, rx_frame_err, tx_req, tx_overrun}, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        run = 1'b1;
        idle(10);
        // R1 R3 R7: single byte with latency
        lat_chk = 1'b1;
        send_frame(8'h61, BIT, -1, 1'b0);
        idle(2 * BIT);
        chk(lat_chk == 1'b0, "R1 strobe seen", lat_chk, 0);
        // R3 R7: several patterns incl. wrap of the offset
        send_frame(8'h00, BIT, -1, 1'b0);
        send_frame(8'hFF, BIT, -1, 1'b0);
        send_frame(8'hA5, BIT, -1, 1'b0);
        send_frame(8'hFE, BIT, -1, 1'b0);
        idle(2 * BIT);
        // R2: short low pulse then a normal byte
        repeat (5) begin @(negedge clk); rx_pin = 1'b0; end
        idle(2 * BIT);
        send_frame(8'h3C, BIT, -1, 1'b0);
        idle(BIT);
        // R4: one-clock inversion at the centre of data bits 0 and 5
        send_frame(8'h5A, BIT, HALF + 1 * BIT, 1'b0);
        send_frame(8'hC3, BIT, HALF + 6 * BIT, 1'b0);
        idle(BIT);
        // R6: stop bit low, line held low, then recovery
        send_frame(8'h77, BIT, -1, 1'b1);
        repeat (20) begin @(negedge clk); rx_pin = 1'b0; end
        idle(2 * BIT);
        send_frame(8'h11, BIT, -1, 1'b0);
        idle(BIT);
        // R5: shortened stop bit, next start follows at once
        send_frame(8'h81, HALF + 3, -1, 1'b0);
        send_frame(8'h42, HALF + 3, -1, 1'b0);
        send_frame(8'h24, BIT, -1, 1'b0);
        idle(2 * BIT);
        // R8: slot full, second byte dropped, then drained
        ack_en = 1'b0;
        send_frame(8'h10, BIT, -1, 1'b0);
        idle(BIT);
        send_frame(8'h20, BIT, -1, 1'b0);
        idle(BIT);
        chk(ovr_seen == 1, "R8 overrun count", ovr_seen, 1);
        chk(tx_req && tx_data == 8'h12, "R8 slot keeps first byte", tx_data, 8'h12);
        ack_en = 1'b1;
        idle(4);
        chk(!tx_req, "R7 req dropped after ack", tx_req, 0);
        chk(exp_q.size() == 0, "R3 all expected frames seen", exp_q.size(), 0);
        run = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule